// File: doc/BRIEF.md
# Idle and Unassigned Cell Filter

This block sits on the receive side of a cell interface. For each received cell, the four header bytes and the HEC byte come in together in one cycle. The block sorts the header into one of three classes: idle, unassigned or normal. It then decides whether the reassembly stage gets the cell or whether the cell is thrown away. Normal cells always go through. Correcting HEC errors and fully checking the HEC of normal cells are left to the reassembly stage.

Four static configuration inputs shape the decision:
- An accept option lets every cell through.
- A GFC mask option leaves the four most significant header bits out of the class match.
- A skip option drops matching cells without looking at the HEC.
- A headerless-HEC option covers 52-byte cells, where no HEC byte exists. In that mode the class comes from the header alone.

When none of these options is set, the HEC is checked as follows:
- An apparent idle cell gets its whole HEC byte checked.
- An apparent unassigned cell gets only the HEC bits that do not depend on its payload-type bits checked.

A cell whose check fails is passed on, so that the stage downstream reports the error.

Top module: `idle_cell_filter`

## Requirements
- R1: A header whose 32 bits equal 0x00000001 (after optional masking, R3) is classified idle, and `dec_idle` is 1 for that cell.
- R2: A header whose bits 31..4 and bit 0 are all 0 (after optional masking, R3) is classified unassigned, whatever bits 3..1 hold; `dec_unassigned` is 1. Any other header, including one with bit 4 set or 0x00000003, is normal.
- R3: With `cfg_mask_gfc` = 1, header bits 31..28 take no part in the idle and unassigned matches. With it at 0, a nonzero value in those bits makes the cell normal.
- R4: With `cfg_accept_idle` = 1, every valid cell is passed (`dec_pass` = 1), whatever its class, HEC or other options.
- R5: Expected HEC = CRC-8 (polynomial x^8+x^2+x+1, initial value 0, header bits taken most significant first) XOR 0x55. With accept, skip and headerless all 0, an idle cell whose HEC byte equals the expected HEC is dropped. If the byte differs in any bit, the cell is passed.
- R6: With accept, skip and headerless all 0, an unassigned cell is dropped when HEC bits 7, 6 and 0 match the expected HEC, whatever bits 5..1 hold. If any of bits 7, 6 or 0 differ, the cell is passed.
- R7: With `cfg_skip_hec` = 1 and accept 0, idle and unassigned cells are dropped on the header match alone, whatever their HEC.
- R8: With `cfg_no_hec` = 1 (52-byte cells) and accept 0, the HEC input is ignored: idle and unassigned cells are dropped on the header match alone.
- R9: A normal cell is always passed, whatever its HEC.
- R10: `dec_valid` is 1 exactly in the cycle after a cycle with `hdr_valid` = 1. When `dec_valid` is 1, exactly one of `dec_pass` and `dec_drop` is 1. Back-to-back cells each get their own decision.
- R11: While `rst_n` is 0 at a clock edge, all outputs are cleared to 0 on that edge. All outputs are 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_valid | input | 1 | Header and HEC byte valid this cycle |
| hdr_word | input | 32 | Four header bytes, first received byte in bits 31..24 |
| hec_byte | input | 8 | Received HEC byte |
| cfg_accept_idle | input | 1 | Pass idle and unassigned cells through |
| cfg_skip_hec | input | 1 | Drop idle and unassigned cells without any HEC check |
| cfg_mask_gfc | input | 1 | Leave header bits 31..28 out of the class match |
| cfg_no_hec | input | 1 | 52-byte cell mode, no HEC byte present |
| dec_valid | output | 1 | Decision valid |
| dec_pass | output | 1 | Cell goes to reassembly |
| dec_drop | output | 1 | Cell is discarded |
| dec_idle | output | 1 | Cell classified idle |
| dec_unassigned | output | 1 | Cell classified unassigned |

## Verification
The block holds no state beyond its one output register, so any internal fault shows at the ports in the very next decision. A CRC stage that is miswired shows up as a drop that should have been a pass, or the reverse, on idle cells. The limited-check mask is probed by faulting each group of HEC bits (checked and unchecked) on unassigned cells. A class match that is off by one bit shows up on boundary headers such as 0x00000003, 0x00000010 and those with a nonzero GFC. Valid timing is checked with gaps in the cell stream, back-to-back cells, and a reset asserted while a cell is present.

// File: rtl/idle_cell_filter_pkg.sv
// Package: shared constants for the idle/unassigned cell filter.
// Assumes a 4-byte header with the GFC in the top nibble and an 8-bit HEC.
package idle_cell_filter_pkg;

    localparam int HDR_BITS  = 32;
    localparam int HEC_BITS  = 8;
    localparam int GFC_BITS  = 4;

    // CRC-8 generator polynomial, lower terms only (x^2 + x + 1)
    localparam logic [HEC_BITS-1:0] HEC_POLY  = 8'h07;
    // Coset added to the remainder
    localparam logic [HEC_BITS-1:0] HEC_COSET = 8'h55;
    // HEC bits that do not depend on payload-type bits 3..1 of an unassigned header
    localparam logic [HEC_BITS-1:0] LIMITED_HEC_MASK = 8'hC1;

    // Idle header pattern and payload-type bits left free for unassigned headers
    localparam logic [HDR_BITS-1:0] IDLE_PATTERN = 32'h0000_0001;
    localparam logic [HDR_BITS-1:0] PTI_FREE     = 32'h0000_000E;

    // Static option set
    typedef struct packed {
        logic accept_idle;
        logic skip_hec;
        logic mask_gfc;
        logic no_hec;
    } filt_cfg_t;

endpackage

// File: rtl/idle_cell_filter_hec.sv
// Module: expected HEC generator.
// Computes a bit-serial CRC-8 over the header, unrolled into a combinational
// chain (most significant bit first), then adds the coset.
// Assumes the header is presented whole in one cycle.
module idle_cell_filter_hec
    import idle_cell_filter_pkg::*;
#(
    parameter int NBITS = HDR_BITS,
    parameter int CBITS = HEC_BITS
) (
    input  logic [NBITS-1:0] hdr,
    output logic [CBITS-1:0] hec_exp
);

    logic [CBITS-1:0] stage [0:NBITS];

    assign stage[0] = '0;

    // One shift/feedback step per header bit
    for (genvar i = 0; i < NBITS; i++) begin : g_step
        logic fb;
        assign fb           = stage[i][CBITS-1] ^ hdr[NBITS-1-i];
        assign stage[i+1]   = {stage[i][CBITS-2:0], 1'b0} ^ (fb ? HEC_POLY : '0);
    end

    // Remainder plus coset
    assign hec_exp = stage[NBITS] ^ HEC_COSET;

endmodule

// File: rtl/idle_cell_filter_class.sv
// Module: header classifier.
// Flags a header as idle or unassigned, optionally with the GFC nibble masked.
// Assumes the idle and unassigned patterns have a zero GFC field.
module idle_cell_filter_class
    import idle_cell_filter_pkg::*;
#(
    parameter int NBITS = HDR_BITS,
    parameter int GBITS = GFC_BITS
) (
    input  logic [NBITS-1:0] hdr,
    input  logic             mask_gfc,
    output logic             is_idle,
    output logic             is_unas
);

    localparam logic [NBITS-1:0] KEEP_ALL = '1;
    localparam logic [NBITS-1:0] KEEP_LOW = {{GBITS{1'b0}}, {(NBITS-GBITS){1'b1}}};

    logic [NBITS-1:0] masked;

    // Apply the optional GFC mask
    always_comb masked = hdr & (mask_gfc ? KEEP_LOW : KEEP_ALL);

    // Compare against the idle and unassigned patterns
    always_comb begin
        is_idle = (masked == IDLE_PATTERN);
        is_unas = ((masked & ~PTI_FREE) == '0);
    end

endmodule

// File: rtl/idle_cell_filter_decide.sv
// Module: pass/drop decision and output register.
// Combines the class flags, HEC comparison and options, then registers the
// result one cycle after the input strobe. Outputs are zero when not valid.
module idle_cell_filter_decide
    import idle_cell_filter_pkg::*;
#(
    parameter int CBITS = HEC_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             is_idle,
    input  logic             is_unas,
    input  logic [CBITS-1:0] hec_rx,
    input  logic [CBITS-1:0] hec_exp,
    input  filt_cfg_t        cfg,
    output logic             out_valid,
    output logic             out_pass,
    output logic             out_drop,
    output logic             out_idle,
    output logic             out_unas
);

    logic full_ok, limited_ok, hec_checked, special, pass_c;

    // HEC comparisons: whole byte for idle, constant bits for unassigned
    always_comb begin
        full_ok    = (hec_rx == hec_exp);
        limited_ok = (((hec_rx ^ hec_exp) & LIMITED_HEC_MASK) == '0);
    end

    // Decide whether the cell continues to reassembly
    always_comb begin
        special     = is_idle | is_unas;
        hec_checked = !(cfg.skip_hec | cfg.no_hec);
        pass_c      = cfg.accept_idle | !special |
                      (hec_checked & (is_idle ? !full_ok : !limited_ok));
    end

    // Output register, cleared by reset and gated by the input strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pass  <= 1'b0;
            out_drop  <= 1'b0;
            out_idle  <= 1'b0;
            out_unas  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_pass  <= in_valid & pass_c;
            out_drop  <= in_valid & !pass_c;
            out_idle  <= in_valid & is_idle;
            out_unas  <= in_valid & is_unas;
        end
    end

    // R4: accept option lets every cell through
    p_accept_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg.accept_idle) |=> out_pass);

    // R9: normal cells always pass
    p_normal_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_idle && !is_unas) |=> out_pass);

    // R7, R8: header match alone drops when HEC is not consulted
    p_nohec_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg.accept_idle && (is_idle || is_unas) &&
         (cfg.skip_hec || cfg.no_hec)) |=> out_drop);

    // R10: exactly one of pass and drop with a valid decision
    p_one_decision_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pass != out_drop));

endmodule

// File: rtl/idle_cell_filter.sv
// Module: top of the idle/unassigned cell filter.
// Classifies each header, computes its expected HEC and emits a registered
// pass/drop decision one cycle after hdr_valid.
// Assumes the configuration inputs are static while cells flow.
module idle_cell_filter
    import idle_cell_filter_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hdr_valid,
    input  logic [31:0] hdr_word,
    input  logic [7:0]  hec_byte,
    input  logic        cfg_accept_idle,
    input  logic        cfg_skip_hec,
    input  logic        cfg_mask_gfc,
    input  logic        cfg_no_hec,
    output logic        dec_valid,
    output logic        dec_pass,
    output logic        dec_drop,
    output logic        dec_idle,
    output logic        dec_unassigned
);

    logic [HEC_BITS-1:0] hec_exp;
    logic                is_idle, is_unas;
    filt_cfg_t           cfg;

    // Gather the option inputs
    always_comb cfg = '{accept_idle: cfg_accept_idle, skip_hec: cfg_skip_hec,
                        mask_gfc: cfg_mask_gfc, no_hec: cfg_no_hec};

    idle_cell_filter_hec #(.NBITS(HDR_BITS), .CBITS(HEC_BITS)) hec_i (
        .hdr     (hdr_word),
        .hec_exp (hec_exp)
    );

    idle_cell_filter_class #(.NBITS(HDR_BITS), .GBITS(GFC_BITS)) class_i (
        .hdr      (hdr_word),
        .mask_gfc (cfg.mask_gfc),
        .is_idle  (is_idle),
        .is_unas  (is_unas)
    );

    idle_cell_filter_decide #(.CBITS(HEC_BITS)) decide_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (hdr_valid),
        .is_idle   (is_idle),
        .is_unas   (is_unas),
        .hec_rx    (hec_byte),
        .hec_exp   (hec_exp),
        .cfg       (cfg),
        .out_valid (dec_valid),
        .out_pass  (dec_pass),
        .out_drop  (dec_drop),
        .out_idle  (dec_idle),
        .out_unas  (dec_unassigned)
    );

    // R10: a decision follows each strobe, and only a strobe
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> dec_valid);
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !dec_valid);

    // R1: the exact idle pattern is reported idle
    p_idle_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_word == 32'h0000_0001) |=> dec_idle);

    // R11: all flags quiet without a decision
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(dec_pass || dec_drop || dec_idle || dec_unassigned));

endmodule

// File: tb/idle_cell_filter_tb_top.sv
module idle_cell_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [31:0] hdr_word = '0;
    logic [7:0]  hec_byte = '0;
    logic        cfg_accept_idle = 1'b0, cfg_skip_hec = 1'b0;
    logic        cfg_mask_gfc = 1'b0, cfg_no_hec = 1'b0;
    logic        dec_valid, dec_pass, dec_drop, dec_idle, dec_unassigned;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_cell_filter dut_i (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
        .hec_byte(hec_byte), .cfg_accept_idle(cfg_accept_idle),
        .cfg_skip_hec(cfg_skip_hec), .cfg_mask_gfc(cfg_mask_gfc),
        .cfg_no_hec(cfg_no_hec), .dec_valid(dec_valid), .dec_pass(dec_pass),
        .dec_drop(dec_drop), .dec_idle(dec_idle), .dec_unassigned(dec_unassigned)
    );

    // Vector: {req#, header, HEC error pattern, cfg {accept,skip,mask,nohec}, exp {pass,idle,unas}}
    localparam logic [50:0] VEC [NV] = '{
        {4'd5,  32'h0000_0001, 8'h00, 4'b0000, 3'b010}, // R5 idle good HEC -> drop
        {4'd5,  32'h0000_0001, 8'h01, 4'b0000, 3'b110}, // R5 idle HEC bit0 bad -> pass
        {4'd5,  32'h0000_0001, 8'h10, 4'b0000, 3'b110}, // R5 idle HEC bit4 bad -> pass
        {4'd6,  32'h0000_0000, 8'h00, 4'b0000, 3'b001}, // R6 unassigned good -> drop
        {4'd2,  32'h0000_000C, 8'h00, 4'b0000, 3'b001}, // R2 PTI bits set, still unassigned
        {4'd6,  32'h0000_000A, 8'h3E, 4'b0000, 3'b001}, // R6 bits 5..1 wrong, ignored
        {4'd6,  32'h0000_0004, 8'h80, 4'b0000, 3'b101}, // R6 bit7 wrong -> pass
        {4'd6,  32'h0000_0000, 8'h40, 4'b0000, 3'b101}, // R6 bit6 wrong -> pass
        {4'd6,  32'h0000_0002, 8'h01, 4'b0000, 3'b101}, // R6 bit0 wrong -> pass
        {4'd9,  32'h1234_5670, 8'hFF, 4'b0000, 3'b100}, // R9 normal, bad HEC -> pass
        {4'd4,  32'h0000_0001, 8'h00, 4'b1000, 3'b110}, // R4 idle accepted
        {4'd4,  32'h0000_0006, 8'hC1, 4'b1101, 3'b101}, // R4 unassigned accepted, all opts
        {4'd7,  32'h0000_0001, 8'hFF, 4'b0100, 3'b010}, // R7 idle bad HEC, skip -> drop
        {4'd7,  32'h0000_0000, 8'h81, 4'b0100, 3'b001}, // R7 unassigned bad HEC, skip -> drop
        {4'd3,  32'hA000_0001, 8'h00, 4'b0000, 3'b100}, // R3 GFC counted -> normal
        {4'd3,  32'hA000_0001, 8'h00, 4'b0010, 3'b010}, // R3 GFC masked -> idle drop
        {4'd8,  32'hA000_0000, 8'hFF, 4'b0011, 3'b001}, // R8 no HEC, masked -> drop
        {4'd8,  32'h0000_0001, 8'hA5, 4'b0001, 3'b010}, // R8 no HEC idle -> drop
        {4'd2,  32'h0000_0010, 8'h00, 4'b0000, 3'b100}, // R2 bit4 set -> normal
        {4'd1,  32'h0000_0003, 8'h00, 4'b0000, 3'b100}  // R1 not idle -> normal
    };

    function automatic logic [7:0] ref_hec(input logic [31:0] h);
        logic [7:0] c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            logic fb = c[7] ^ h[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c ^ 8'h55;
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] h, input logic [7:0] herr, input logic [3:0] c);
        hdr_valid = 1'b1;
        hdr_word  = h;
        hec_byte  = ref_hec(h) ^ herr;
        {cfg_accept_idle, cfg_skip_hec, cfg_mask_gfc, cfg_no_hec} = c;
    endtask

    task automatic check_dec(input string tag, input logic [2:0] e);
        check(tag, "valid", {7'd0, dec_valid}, 8'd1);
        check(tag, "pass",  {7'd0, dec_pass},  {7'd0, e[2]});
        check(tag, "drop",  {7'd0, dec_drop},  {7'd0, ~e[2]});
        check(tag, "idle",  {7'd0, dec_idle},  {7'd0, e[1]});
        check(tag, "unas",  {7'd0, dec_unassigned}, {7'd0, e[0]});
    endtask

    task automatic check_quiet(input string tag);
        check(tag, "quiet", {3'd0, dec_valid, dec_pass, dec_drop, dec_idle, dec_unassigned}, 8'd0);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check_quiet("R11 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R11 idle after reset");

        // Table walk
        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[k][50:47], k);
            drive(VEC[k][46:15], VEC[k][14:7], VEC[k][6:3]);
            @(negedge clk);
            hdr_valid = 1'b0;
            check_dec(tag, VEC[k][2:0]);
            @(negedge clk);
            check_quiet({tag, " gap R10"});
        end

        // R10: back-to-back cells, each decided one cycle later
        drive(32'h0000_0001, 8'h00, 4'b0000);
        @(negedge clk);
        check_dec("R10 b2b first", 3'b010);
        drive(32'h0000_0001, 8'h02, 4'b0000);
        @(negedge clk);
        check_dec("R10 b2b second", 3'b110);
        drive(32'h0000_0008, 8'h00, 4'b0000);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_dec("R10 b2b third", 3'b001);
        @(negedge clk);
        check_quiet("R10 after burst");

        // R11: reset asserted while a cell is presented
        drive(32'h0000_0001, 8'h00, 4'b0000);
        rst_n = 1'b0;
        @(negedge clk);
        check_quiet("R11 reset with valid");
        hdr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R11 release");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule